// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

This block keeps a record of loads that were allowed to execute before every older store had resolved its address. Each executed load claims one slot holding its instruction number and its address tag. When an older store later resolves its address, the store presents that address and its own instruction number. All occupied slots are compared against it in parallel. A younger load that has already read the same address has returned stale data, so the block reports a violation and names the oldest such load. Replay can then restart from that load.

Loads leave the block through two ports. A commit port frees the slot of one retiring load. An abort port frees every slot from a squashed instruction number onward. The block does not flush or replay anything itself. It only reports the offending load. Instruction numbers wrap around, so age is judged by modular difference.

Top module: `load_order_guard`

## Requirements
- R1: While `rst_n` is low and at the first clock edge after it rises, no slot is occupied, `ld_full` is 0 and `viol_valid` is 0.
- R2: A cycle with `ld_valid` high and `ld_full` low stores `ld_inum` and `ld_tag` in a free slot, and that slot is occupied from the next clock edge.
- R3: A search (`st_valid` high) reports a violation when an occupied slot has a tag equal to `st_tag` and an instruction number younger than `st_inum`. The report sets `viol_valid` to 1 and puts that slot's instruction number on `viol_inum`.
- R4: A search reports no violation when every matching-tag slot is older than the store or equal to it, or when no slot matches the tag. A cycle with `st_valid` low never produces a violation.
- R5: `viol_valid` reflects the search made in the previous cycle only. It is high for exactly one cycle per violating search and is 0 after any cycle without a violating search.
- R6: When several slots violate in one search, `viol_inum` carries the oldest of them.
- R7: `cm_valid` frees the occupied slot whose instruction number equals `cm_inum`. A later search no longer sees that slot.
- R8: `ab_valid` frees every occupied slot whose instruction number equals `ab_inum` or is younger than it. Older slots are kept.
- R9: `ld_full` is 1 exactly when all `ENTRIES` slots are occupied. A load presented while `ld_full` is 1 is dropped and can never cause a violation.
- R10: Instruction number A is younger than B when (A − B) modulo 2^`INUM_W` is nonzero and below 2^(`INUM_W`−1). For example, with `INUM_W`=6, 2 is younger than 60.
- R11: A search, commit or abort in a given cycle acts only on slots occupied before that cycle. A load written in the same cycle is neither reported nor freed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A load has executed this cycle |
| ld_inum | input | INUM_W | Instruction number of the executing load |
| ld_tag | input | TAG_W | Address tag read by the load |
| ld_full | output | 1 | All slots occupied; a load now is dropped |
| st_valid | input | 1 | A store address has resolved; search the slots |
| st_inum | input | INUM_W | Instruction number of the searching store |
| st_tag | input | TAG_W | Address tag of the store |
| cm_valid | input | 1 | A load commits |
| cm_inum | input | INUM_W | Instruction number of the committing load |
| ab_valid | input | 1 | Squash from an instruction number onward |
| ab_inum | input | INUM_W | Oldest squashed instruction number |
| viol_valid | output | 1 | Violation found by the previous cycle's search |
| viol_inum | output | INUM_W | Instruction number of the oldest violating load |

## Verification
There are two kinds of result, and each is due at a different time. The violation result of a search is registered, so it appears one clock edge after the cycle in which the search is presented. `ld_full` is a combinational function of the slots, so it is valid in the same cycle as any new request. The driver presents every request at a falling edge and checks `ld_full` just after that edge. It then queues the expected violation result for the request. The monitor takes one item from the queue two nanoseconds after each rising edge, so each result is compared exactly one edge after its stimulus. Because every cycle queues an item, including idle and load-only cycles, a pulse that lasts too long or comes a cycle late is also caught.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

   typedef enum logic {
      AGE_MODULAR = 1'b0,
      AGE_LINEAR  = 1'b1
   } age_mode_e;

   // a is younger than b, judged on the low w bits
   function automatic logic age_newer(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned w,
                                      input age_mode_e   m);
      logic [31:0] mask;
      logic [31:0] d;
      mask = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
      if (m == AGE_MODULAR) begin
         d = (a - b) & mask;
         return (d != 32'd0) && (d[w-1] == 1'b0);
      end
      return (a & mask) > (b & mask);
   endfunction

endpackage

// File: rtl/lsg_alloc.sv
module lsg_alloc #(
   parameter int unsigned ENTRIES = 8
) (
   input  logic [ENTRIES-1:0] busy,
   output logic [ENTRIES-1:0] grant,
   output logic               full
);

   // lowest-index free slot wins
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!busy[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign full = &busy;

endmodule

// File: rtl/lsg_entry.sv
module lsg_entry
   import lsg_pkg::*;
#(
   parameter int unsigned INUM_W   = 6,
   parameter int unsigned TAG_W    = 12,
   parameter age_mode_e   AGE_MODE = AGE_MODULAR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [INUM_W-1:0] ld_inum,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic              cm_valid,
   input  logic [INUM_W-1:0] cm_inum,
   input  logic              ab_valid,
   input  logic [INUM_W-1:0] ab_inum,
   input  logic              st_valid,
   input  logic [INUM_W-1:0] st_inum,
   input  logic [TAG_W-1:0]  st_tag,
   output logic              busy,
   output logic [INUM_W-1:0] inum,
   output logic              hit
);

   logic              valid_q;
   logic [INUM_W-1:0] inum_q;
   logic [TAG_W-1:0]  tag_q;
   logic              kill_cm;
   logic              kill_ab;

   assign kill_cm = cm_valid && (inum_q == cm_inum);
   assign kill_ab = ab_valid &&
                    ((inum_q == ab_inum) ||
                     age_newer(32'(inum_q), 32'(ab_inum), INUM_W, AGE_MODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         inum_q  <= '0;
         tag_q   <= '0;
      end else if (alloc) begin
         // allocator only grants a free slot, so no kill applies here
         valid_q <= 1'b1;
         inum_q  <= ld_inum;
         tag_q   <= ld_tag;
      end else if (valid_q && (kill_cm || kill_ab)) begin
         valid_q <= 1'b0;
      end
   end

   assign busy = valid_q;
   assign inum = inum_q;
   assign hit  = valid_q && st_valid && (tag_q == st_tag) &&
                 age_newer(32'(inum_q), 32'(st_inum), INUM_W, AGE_MODE);

endmodule

// File: rtl/lsg_pick.sv
module lsg_pick
   import lsg_pkg::*;
#(
   parameter int unsigned ENTRIES  = 8,
   parameter int unsigned INUM_W   = 6,
   parameter age_mode_e   AGE_MODE = AGE_MODULAR
) (
   input  logic [ENTRIES-1:0]             hit,
   input  logic [ENTRIES-1:0][INUM_W-1:0] inum,
   output logic                           any,
   output logic [INUM_W-1:0]              oldest
);

   always_comb begin
      any    = 1'b0;
      oldest = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit[i] &&
             (!any || age_newer(32'(oldest), 32'(inum[i]), INUM_W, AGE_MODE))) begin
            any    = 1'b1;
            oldest = inum[i];
         end
      end
   end

endmodule

// File: rtl/load_order_guard.sv
module load_order_guard
   import lsg_pkg::*;
#(
   parameter int unsigned ENTRIES  = 8,
   parameter int unsigned INUM_W   = 6,
   parameter int unsigned TAG_W    = 12,
   parameter age_mode_e   AGE_MODE = AGE_MODULAR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [INUM_W-1:0] ld_inum,
   input  logic [TAG_W-1:0]  ld_tag,
   output logic              ld_full,
   input  logic              st_valid,
   input  logic [INUM_W-1:0] st_inum,
   input  logic [TAG_W-1:0]  st_tag,
   input  logic              cm_valid,
   input  logic [INUM_W-1:0] cm_inum,
   input  logic              ab_valid,
   input  logic [INUM_W-1:0] ab_inum,
   output logic              viol_valid,
   output logic [INUM_W-1:0] viol_inum
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("load_order_guard: ENTRIES must be at least 2");
   end
   if (INUM_W < 2 || INUM_W > 31) begin : g_bad_inum
      $error("load_order_guard: INUM_W must lie in 2..31");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("load_order_guard: TAG_W must be at least 1");
   end

   logic [ENTRIES-1:0]             busy_vec;
   logic [ENTRIES-1:0]             grant_vec;
   logic [ENTRIES-1:0]             alloc_vec;
   logic [ENTRIES-1:0]             hit_vec;
   logic [ENTRIES-1:0][INUM_W-1:0] slot_inum;
   logic                           full;
   logic                           pick_any;
   logic [INUM_W-1:0]              pick_inum;
   logic                           viol_q;
   logic [INUM_W-1:0]              viol_inum_q;

   lsg_alloc #(.ENTRIES(ENTRIES)) u_alloc (
      .busy  (busy_vec),
      .grant (grant_vec),
      .full  (full)
   );

   assign alloc_vec = ld_valid ? grant_vec : '0;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      lsg_entry #(
         .INUM_W   (INUM_W),
         .TAG_W    (TAG_W),
         .AGE_MODE (AGE_MODE)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (alloc_vec[g]),
         .ld_inum  (ld_inum),
         .ld_tag   (ld_tag),
         .cm_valid (cm_valid),
         .cm_inum  (cm_inum),
         .ab_valid (ab_valid),
         .ab_inum  (ab_inum),
         .st_valid (st_valid),
         .st_inum  (st_inum),
         .st_tag   (st_tag),
         .busy     (busy_vec[g]),
         .inum     (slot_inum[g]),
         .hit      (hit_vec[g])
      );
   end

   lsg_pick #(
      .ENTRIES  (ENTRIES),
      .INUM_W   (INUM_W),
      .AGE_MODE (AGE_MODE)
   ) u_pick (
      .hit    (hit_vec),
      .inum   (slot_inum),
      .any    (pick_any),
      .oldest (pick_inum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_q      <= 1'b0;
         viol_inum_q <= '0;
      end else begin
         viol_q <= pick_any;
         if (pick_any) begin
            viol_inum_q <= pick_inum;
         end
      end
   end

   assign ld_full    = full;
   assign viol_valid = viol_q;
   assign viol_inum  = viol_inum_q;

endmodule

// File: rtl/lsg_checker.sv
module lsg_checker
   import lsg_pkg::*;
#(
   parameter int unsigned ENTRIES  = 8,
   parameter int unsigned INUM_W   = 6,
   parameter age_mode_e   AGE_MODE = AGE_MODULAR
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_valid,
   input logic               ld_full,
   input logic               cm_valid,
   input logic               ab_valid,
   input logic               st_valid,
   input logic [INUM_W-1:0]  st_inum,
   input logic               viol_valid,
   input logic [INUM_W-1:0]  viol_inum,
   input logic [ENTRIES-1:0] busy
);

   // R1: reset empties every slot and clears the report
   p_reset_empty_r1: assert property (@(posedge clk)
      !rst_n |=> (busy == '0) && !viol_valid);

   // R2: an accepted load with no release adds exactly one slot
   p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && !ld_full && !cm_valid && !ab_valid
      |=> $countones(busy) == $past($countones(busy)) + 1);

   // R3: a reported load is younger than the store that searched
   p_viol_younger_r3: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> age_newer(32'(viol_inum), 32'($past(st_inum)), INUM_W, AGE_MODE));

   // R5: a report needs a search in the previous cycle
   p_viol_after_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> $past(st_valid));

   // R9: a load offered while full leaves the slots full
   p_full_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && ld_full && !cm_valid && !ab_valid
      |=> $countones(busy) == ENTRIES);

endmodule

bind load_order_guard lsg_checker #(
   .ENTRIES  (ENTRIES),
   .INUM_W   (INUM_W),
   .AGE_MODE (AGE_MODE)
) u_lsg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_valid   (ld_valid),
   .ld_full    (ld_full),
   .cm_valid   (cm_valid),
   .ab_valid   (ab_valid),
   .st_valid   (st_valid),
   .st_inum    (st_inum),
   .viol_valid (viol_valid),
   .viol_inum  (viol_inum),
   .busy       (busy_vec)
);

// File: tb/test_load_order_guard.sv
module test_load_order_guard;

   localparam int E  = 8;
   localparam int IW = 6;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 1'b0;
   logic [IW-1:0] ld_inum = '0;
   logic [TW-1:0] ld_tag = '0;
   logic          ld_full;
   logic          st_valid = 1'b0;
   logic [IW-1:0] st_inum = '0;
   logic [TW-1:0] st_tag = '0;
   logic          cm_valid = 1'b0;
   logic [IW-1:0] cm_inum = '0;
   logic          ab_valid = 1'b0;
   logic [IW-1:0] ab_inum = '0;
   logic          viol_valid;
   logic [IW-1:0] viol_inum;

   always #10 clk = ~clk;   // 50 MHz

   load_order_guard #(.ENTRIES(E), .INUM_W(IW), .TAG_W(TW)) i_load_order_guard (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_inum(ld_inum), .ld_tag(ld_tag), .ld_full(ld_full),
      .st_valid(st_valid), .st_inum(st_inum), .st_tag(st_tag),
      .cm_valid(cm_valid), .cm_inum(cm_inum),
      .ab_valid(ab_valid), .ab_inum(ab_inum),
      .viol_valid(viol_valid), .viol_inum(viol_inum)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit            v;
      logic [IW-1:0] inum;
      string         req;
   } exp_t;
   exp_t q[$];

   bit            m_v    [E];
   logic [IW-1:0] m_inum [E];
   logic [TW-1:0] m_tag  [E];

   function automatic bit younger(input logic [IW-1:0] a, input logic [IW-1:0] b);
      int d;
      d = (int'(a) - int'(b) + (1 << IW)) % (1 << IW);
      return (d != 0) && (d < (1 << (IW - 1)));
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, expected result queued for the monitor
   task automatic cyc(input bit ldv, input int li, input int lt,
                      input bit stv, input int si, input int sti,
                      input bit cmv, input int ci,
                      input bit abv, input int ai,
                      input string req);
      int   slot;
      int   cnt;
      exp_t e;
      @(negedge clk);
      ld_valid = ldv; ld_inum = IW'(li); ld_tag = TW'(lt);
      st_valid = stv; st_inum = IW'(si); st_tag = TW'(sti);
      cm_valid = cmv; cm_inum = IW'(ci);
      ab_valid = abv; ab_inum = IW'(ai);
      #1;
      slot = -1;
      cnt  = 0;
      for (int i = 0; i < E; i++) begin
         if (m_v[i]) cnt++;
         else if (slot < 0) slot = i;
      end
      check(ld_full == (cnt == E), "R9", "ld_full", int'(ld_full), int'(cnt == E));
      e.v = 1'b0; e.inum = '0; e.req = req;
      for (int i = 0; i < E; i++) begin
         if (stv && m_v[i] && m_tag[i] == TW'(sti) && younger(m_inum[i], IW'(si))) begin
            if (!e.v || younger(e.inum, m_inum[i])) begin
               e.v = 1'b1;
               e.inum = m_inum[i];
            end
         end
      end
      q.push_back(e);
      for (int i = 0; i < E; i++) begin
         if (m_v[i] && ((cmv && m_inum[i] == IW'(ci)) ||
                        (abv && (m_inum[i] == IW'(ai) || younger(m_inum[i], IW'(ai))))))
            m_v[i] = 1'b0;
      end
      if (ldv && slot >= 0) begin
         m_v[slot] = 1'b1;
         m_inum[slot] = IW'(li);
         m_tag[slot] = TW'(lt);
      end
   endtask

   task automatic idle(input string req);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
   endtask
   task automatic load(input int li, input int lt, input string req);
      cyc(1, li, lt, 0, 0, 0, 0, 0, 0, 0, req);
   endtask
   task automatic search(input int si, input int sti, input string req);
      cyc(0, 0, 0, 1, si, sti, 0, 0, 0, 0, req);
   endtask
   task automatic commit(input int ci, input string req);
      cyc(0, 0, 0, 0, 0, 0, 1, ci, 0, 0, req);
   endtask
   task automatic abort(input int ai, input string req);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, ai, req);
   endtask

   // monitor: each result is due one rising edge after its stimulus
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(viol_valid == e.v, e.req, "viol_valid", int'(viol_valid), int'(e.v));
            if (e.v)
               check(viol_inum == e.inum, e.req, "viol_inum", int'(viol_inum), int'(e.inum));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < E; i++) begin
         m_v[i] = 1'b0; m_inum[i] = '0; m_tag[i] = '0;
      end
      repeat (3) @(negedge clk);
      #1;
      check(ld_full == 1'b0, "R1", "ld_full in reset", int'(ld_full), 0);
      check(viol_valid == 1'b0, "R1", "viol_valid in reset", int'(viol_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check(viol_valid == 1'b0 && ld_full == 1'b0, "R1", "state after reset",
            int'(viol_valid) + int'(ld_full), 0);

      // R2/R3: younger load hit by an older store
      load(10, 'hA0, "R2");
      search(5, 'hA0, "R3");
      idle("R5");
      // R4: older store side, equal number, other tag
      search(12, 'hA0, "R4");
      search(10, 'hA0, "R4");
      search(5, 'hB0, "R4");
      // R6: several violators, oldest reported
      load(14, 'hA0, "R2");
      load(12, 'hA0, "R2");
      search(8, 'hA0, "R6");
      search(11, 'hA0, "R6");
      search(8, 'hA0, "R5");   // back-to-back pulses
      // R7: commit frees one slot
      commit(10, "R7");
      search(8, 'hA0, "R7");
      // R8: abort frees 14 and later, keeps 12
      abort(13, "R8");
      search(12, 'hA0, "R8");
      search(8, 'hA0, "R8");
      commit(12, "R7");
      search(8, 'hA0, "R7");
      // R9: fill all slots, extra load dropped
      for (int k = 0; k < E; k++) load(20 + k, 'h100 + k, "R9");
      load(28, 'h7, "R9");
      search(19, 'h7, "R9");
      search(19, 'h103, "R9");
      abort(20, "R8");
      idle("R9");
      // R10: wrap-around age
      load(2, 'hC0, "R10");
      search(60, 'hC0, "R10");
      load(62, 'hD0, "R10");
      search(1, 'hD0, "R10");
      commit(2, "R7");
      commit(62, "R7");
      // R11: same-cycle load with search, then with abort
      cyc(1, 40, 'hE0, 1, 30, 'hE0, 0, 0, 0, 0, "R11");
      search(30, 'hE0, "R11");
      cyc(1, 41, 'hE0, 0, 0, 0, 0, 0, 1, 40, "R11");
      search(30, 'hE0, "R11");
      idle("R5");
      idle("R5");
      @(posedge clk);
      #3;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule